// File: doc/BRIEF.md
# Reloading Down-Count Timer Channel

This block is one channel of a general-purpose interval timer. A counter register counts down by one each time a prescaler, driven by the block clock, completes a period. Software selects that period through a divider code in the control register. When the counter is already at zero on a count step, it takes its next value from a reload register instead of decrementing, and it raises a sticky underflow flag. The flag, gated by an interrupt-enable bit, drives the interrupt output.

A run input from the surrounding timer unit starts and stops the channel. Software reaches four word-sized registers through a select code with a write strobe and a combinational read path: reload value, live counter, control, and an optional capture holding register. Software acknowledges an underflow by writing the control register with the flag bit at zero. Writing the flag bit as one keeps the flag as it is, so software can change other control fields without losing a pending event.

Top module: `timer_chan`

## Requirements
- R1: After reset, the reload register and the counter both read 0xFFFFFFFF, the control register reads 0, the capture register reads 0 and `irq` is low.
- R2: Register select 0 is the reload value, 1 is the counter, 2 is control and 3 is capture. A write with select 0 or 3 stores the data, and a write with select 1 loads the counter directly. `rdata` shows the selected register in the same cycle. When the capture option is off, select 3 reads 0 and writes to it are dropped.
- R3: Control bits [2:0] hold the divider code. Code c, for c from 0 to 4, gives one count step every 4·4^c clocks while `run_en` is high. If the counter and reload both hold R, the first underflow lands (R+1)·4·4^c clocks after a control write.
- R4: Divider codes 5, 6 and 7 produce no count steps, and the counter holds its value.
- R5: While `run_en` is low, the counter holds its value and the prescaler stays at its start.
- R6: A count step taken with the counter at 0 loads the reload value into the counter and sets the underflow flag, which reads at control bit 8.
- R7: A control write with bit 8 at 0 clears the flag. A control write with bit 8 at 1 leaves the flag unchanged. No write ever sets the flag. An underflow in the same cycle as a clearing write wins.
- R8: `irq` is high exactly when the flag is set and control bit 5 (interrupt enable) is set.
- R9: A control read returns the stored bits [7:0] and the flag at bit 8. Bits [31:9] read 0, whatever was written to them.
- R10: Every control write restarts the prescaler, so the next count step comes a full divider period after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Start/stop gate from the timer unit |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 reload, 1 counter, 2 control, 3 capture) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Underflow interrupt |

## Verification
The counter, the flag and the prescaler all change on the clock edge that takes a write. A read is combinational, so the bench reads each register at the falling edge after the write. A count step registers on the edge k·N after a control write, and the bench counts falling edges from that write to find the first one where the flag reads set. That count must equal (R+1)·N exactly, for each divider code and for two back-to-back periods. For the prescaler restart, the bench samples the counter one falling edge before and one after the step it predicts. A late or early step shows as a stale or already-decremented value at one of those two points.

// File: rtl/timer_chan_pkg.sv
package timer_chan_pkg;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_CAPT   = 2'd3
    } reg_sel_e;

    // Stored control bits [7:0]; field order fixes bit positions.
    typedef struct packed {
        logic [1:0] capt_mode;  // [7:6] stored only
        logic       irq_en;     // [5]
        logic [1:0] edge_mode;  // [4:3] stored only
        logic [2:0] div_code;   // [2:0]
    } ctl_t;

    localparam int CTL_W     = $bits(ctl_t);
    localparam int FLAG_BIT  = 8;
    localparam int BASE_DIV  = 4;
    localparam int DIV_SHIFT = 2;

endpackage

// File: rtl/timer_chan_presc.sv
module timer_chan_presc #(
    parameter int DIV_STEPS = 5,
    parameter int MAX_DIV   = timer_chan_pkg::BASE_DIV << (timer_chan_pkg::DIV_SHIFT * (DIV_STEPS - 1)),
    parameter int PS_W      = $clog2(MAX_DIV)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       restart,
    input  logic [2:0] div_code,
    output logic       tick
);
    import timer_chan_pkg::*;

    typedef struct packed {
        logic [PS_W-1:0] cnt;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic [PS_W-1:0] term_tbl [DIV_STEPS];
    logic [PS_W-1:0] term;
    logic            code_ok;

    for (genvar g = 0; g < DIV_STEPS; g++) begin : g_term
        assign term_tbl[g] = PS_W'((BASE_DIV << (DIV_SHIFT * g)) - 1);
    end

    always_comb begin
        term    = '0;
        code_ok = 1'b0;
        for (int i = 0; i < DIV_STEPS; i++) begin
            if (div_code == 3'(i)) begin
                term    = term_tbl[i];
                code_ok = 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (restart || !run_en || !code_ok) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == term) begin
            st_d.cnt = '0;
            tick     = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/timer_chan_count.sv
module timer_chan_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_val,
    output logic             underflow
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        underflow = tick && (st_q.cnt == '0);
        if (load_en) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            if (st_q.cnt == '0) st_d.cnt = reload_val;
            else                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign cnt_val = st_q.cnt;

endmodule

// File: rtl/timer_chan_regs.sv
module timer_chan_regs #(
    parameter int CNT_W    = 32,
    parameter bit HAS_CAPT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       reg_sel,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             underflow,
    output logic [CNT_W-1:0] rdata,
    output logic [CNT_W-1:0] reload_val,
    output logic [2:0]       div_code,
    output logic             irq_en,
    output logic             flag,
    output logic             restart,
    output logic             cnt_load,
    output logic             irq
);
    import timer_chan_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] capt;
        ctl_t             ctl;
        logic             flag;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       wr_ctl;

    always_comb begin
        st_d     = st_q;
        wr_ctl   = wr_en && (reg_sel == SEL_CTRL);
        cnt_load = wr_en && (reg_sel == SEL_COUNT);
        restart  = wr_ctl;
        if (wr_en && (reg_sel == SEL_RELOAD)) st_d.reload = wdata;
        if (HAS_CAPT && wr_en && (reg_sel == SEL_CAPT)) st_d.capt = wdata;
        if (wr_ctl) begin
            st_d.ctl = ctl_t'(wdata[CTL_W-1:0]);
            if (!wdata[FLAG_BIT]) st_d.flag = 1'b0;
        end
        if (underflow) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.reload <= '1;
            st_q.capt   <= '0;
            st_q.ctl    <= '0;
            st_q.flag   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_RELOAD: rdata = st_q.reload;
            SEL_COUNT:  rdata = cnt_val;
            SEL_CTRL:   rdata = CNT_W'({st_q.flag, st_q.ctl});
            default:    rdata = HAS_CAPT ? st_q.capt : '0;
        endcase
    end

    assign reload_val = st_q.reload;
    assign div_code   = st_q.ctl.div_code;
    assign irq_en     = st_q.ctl.irq_en;
    assign flag       = st_q.flag;
    assign irq        = st_q.flag & st_q.ctl.irq_en;

endmodule

// File: rtl/timer_chan.sv
module timer_chan #(
    parameter int CNT_W     = 32,
    parameter int DIV_STEPS = 5,
    parameter bit HAS_CAPT  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             wr_en,
    input  logic [1:0]       reg_sel,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             irq
);
    logic             tick;
    logic             restart;
    logic             cnt_load;
    logic             underflow;
    logic             flag;
    logic             irq_en;
    logic [2:0]       div_code;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] reload_val;

    timer_chan_presc #(.DIV_STEPS(DIV_STEPS)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .restart  (restart),
        .div_code (div_code),
        .tick     (tick)
    );

    timer_chan_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load_en    (cnt_load),
        .load_val   (wdata),
        .reload_val (reload_val),
        .cnt_val    (cnt_val),
        .underflow  (underflow)
    );

    timer_chan_regs #(.CNT_W(CNT_W), .HAS_CAPT(HAS_CAPT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .reg_sel    (reg_sel),
        .wdata      (wdata),
        .cnt_val    (cnt_val),
        .underflow  (underflow),
        .rdata      (rdata),
        .reload_val (reload_val),
        .div_code   (div_code),
        .irq_en     (irq_en),
        .flag       (flag),
        .restart    (restart),
        .cnt_load   (cnt_load),
        .irq        (irq)
    );

endmodule

// File: rtl/timer_chan_chk.sv
module timer_chan_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             wr_en,
    input logic [1:0]       reg_sel,
    input logic [CNT_W-1:0] wdata,
    input logic             tick,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] reload_val,
    input logic             flag,
    input logic             irq_en,
    input logic             irq
);
    import timer_chan_pkg::*;

    logic cnt_wr, clr_wr, at_zero;
    assign cnt_wr  = wr_en && (reg_sel == SEL_COUNT);
    assign clr_wr  = wr_en && (reg_sel == SEL_CTRL) && !wdata[FLAG_BIT];
    assign at_zero = (cnt_val == '0);

    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !at_zero && !cnt_wr) |=> (cnt_val == $past(cnt_val) - 1'b1));

    a_r5_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run_en);

    a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !cnt_wr) |=> $stable(cnt_val));

    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_zero && !cnt_wr) |=> (cnt_val == $past(reload_val)));

    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_zero) |=> flag);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_wr) |=> flag);

    a_r7_no_write_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !(tick && at_zero)) |=> !flag);

    a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> (flag && (irq || !irq_en || $changed(irq_en))));

endmodule

bind timer_chan timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .wr_en      (wr_en),
    .reg_sel    (reg_sel),
    .wdata      (wdata),
    .tick       (tick),
    .cnt_val    (cnt_val),
    .reload_val (reload_val),
    .flag       (flag),
    .irq_en     (irq_en),
    .irq        (irq)
);

// File: tb/timer_chan_tb.sv
module timer_chan_tb;
    localparam int RL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd2;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    timer_chan u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq     (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; reg_sel = 2'd2;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        reg_sel = s;
        #1;
        d = rdata;
        reg_sel = 2'd2;
    endtask

    task automatic wait_flag(input int limit, output int n);
        logic [31:0] v;
        n = 0;
        v = '0;
        while (n <= limit && !v[8]) begin
            @(negedge clk);
            n++;
            rd(2'd2, v);
        end
    endtask

    task automatic period_check(input int code);
        int n;
        int expn;
        logic [31:0] v;
        expn = (RL + 1) * (4 << (2 * code));
        run_en = 1'b0;
        wr(2'd1, RL);
        wr(2'd0, RL);
        run_en = 1'b1;
        wr(2'd2, 32'(code));
        wait_flag(expn + 8, n);
        check($sformatf("R3 code %0d first period", code), n, expn);
        rd(2'd1, v);
        check($sformatf("R6 code %0d counter reloaded", code), v, RL);
        wr(2'd2, 32'(code));
        wait_flag(expn + 8, n);
        check($sformatf("R3 R6 code %0d second period", code), n, expn);
        run_en = 1'b0;
        check($sformatf("R8 code %0d irq masked", code), 32'(irq), 0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(2'd0, v); check("R1 reload reset", v, 32'hFFFF_FFFF);
        rd(2'd1, v); check("R1 counter reset", v, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R1 control reset", v, 32'h0);
        rd(2'd3, v); check("R1 capture reset", v, 32'h0);
        check("R1 irq reset", 32'(irq), 0);

        for (int c = 0; c < 5; c++) period_check(c);

        // flag is set here with run stopped
        wr(2'd2, 32'h120);
        rd(2'd2, v); check("R7 write one keeps flag", v, 32'h120);
        check("R8 irq with flag and enable", 32'(irq), 1);
        wr(2'd2, 32'h100);
        rd(2'd2, v); check("R7 flag kept, enable off", v, 32'h100);
        check("R8 irq off when disabled", 32'(irq), 0);
        wr(2'd2, 32'h020);
        rd(2'd2, v); check("R7 write zero clears flag", v, 32'h020);
        check("R8 irq off after clear", 32'(irq), 0);
        wr(2'd2, 32'h120);
        rd(2'd2, v); check("R7 write never sets flag", v, 32'h020);
        check("R8 irq stays low", 32'(irq), 0);

        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R9 upper control bits read zero", v, 32'h0000_00FF);
        wr(2'd2, 32'hA5A5_FE5A);
        rd(2'd2, v); check("R9 stored low byte only", v, 32'h0000_005A);

        // R10: prescaler restart on control write
        run_en = 1'b0;
        wr(2'd1, 32'd10);
        run_en = 1'b1;
        wr(2'd2, 32'h0);
        wr(2'd2, 32'h0);
        repeat (3) @(negedge clk);
        rd(2'd1, v); check("R10 no step before restarted period", v, 32'd10);
        @(negedge clk);
        rd(2'd1, v); check("R10 step one period after restart", v, 32'd9);

        run_en = 1'b0;
        repeat (100) @(negedge clk);
        rd(2'd1, v); check("R5 counter holds while stopped", v, 32'd9);

        run_en = 1'b1;
        wr(2'd2, 32'h5);
        repeat (300) @(negedge clk);
        rd(2'd1, v); check("R4 code 5 halts", v, 32'd9);
        wr(2'd2, 32'h7);
        repeat (300) @(negedge clk);
        rd(2'd1, v); check("R4 code 7 halts", v, 32'd9);
        run_en = 1'b0;

        wr(2'd0, 32'h1234_5678);
        rd(2'd0, v); check("R2 reload readback", v, 32'h1234_5678);
        wr(2'd1, 32'hA5A5_0F0F);
        rd(2'd1, v); check("R2 counter direct load", v, 32'hA5A5_0F0F);
        wr(2'd3, 32'hDEAD_0001);
        rd(2'd3, v); check("R2 capture readback", v, 32'hDEAD_0001);
        rd(2'd0, v); check("R2 reload unaffected", v, 32'h1234_5678);

        finish_run();
    end

endmodule